// File: doc/BRIEF.md
# Frame-Alternating Colour Dither for One-Bit-per-Channel Video

This block sits between a pixel source and a video port that has one digital line per colour channel. Each pixel carries two 3-bit RGB words. A frame-parity flag flips at every frame boundary. In the two frames of each pair, each channel's pin is driven from a different combination of the two words, so the pin is lit for zero, one or two frames. The eye averages the two frames into three intensity levels per channel, which gives 27 colours instead of 8.

Each channel's level is the number of its two word bits that are set. At the middle level, the channel lights in the even frame only. Every channel follows this rule, so all mid-level channels light together, which keeps the flicker in phase across the picture. A bypass input always sends the first word, which gives plain 8-colour output. Outside active video, the pins are held dark. The output is registered and has one pixel-clock cycle of latency, which matches the delay applied to the sync signals.

Top module: `vga_frame_dither`

## Requirements
- R1: While rst_ni is low, rgb_o is 0 and the frame parity is cleared to even, so the first frame after reset uses the even-frame rule.
- R2: color_i[2:0] is word A and color_i[5:3] is word B. In each word, bit 2 is red, bit 1 is green and bit 0 is blue, and rgb_o uses the same bit order.
- R3: In an even frame with bypass low and active video high, each output channel is the OR of its word A and word B bits.
- R4: In an odd frame with bypass low and active video high, each output channel is the AND of its word A and word B bits.
- R5: For colour inputs held fixed over an even frame and the odd frame after it, each channel is lit for a number of frames equal to the count of its set bits (0, 1 or 2). At the middle level, the channel is lit in the even frame.
- R6: The parity toggles once on each rising edge of frame_i. A frame_i held high causes no further toggles, and the parity changes at no other time.
- R7: When active_i is low, rgb_o is 0 regardless of parity, bypass or colour.
- R8: When bypass_i is high and active_i is high, rgb_o equals word A regardless of parity.
- R9: rgb_o is registered: it reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| color_i | input | 6 | Two RGB words: B in [5:3], A in [2:0] |
| active_i | input | 1 | Active-video flag |
| frame_i | input | 1 | Frame strobe or vertical sync; its rising edge marks a frame boundary |
| bypass_i | input | 1 | Send word A only (8-colour mode) |
| rgb_o | output | 3 | Registered colour pins: red, green, blue |

## Verification
Assertions check on every cycle that blanking forces dark pins, that bypass passes word A, and that the even-frame (OR) and odd-frame (AND) rules hold with one cycle of delay. They also check that the parity flips only on a rising frame edge and stays still while the strobe is held. The on-count over a frame pair, which is the visible intensity, can only be shown by the bench's scenarios. These run whole frames with fixed colours, aligned to an even frame. The bench's directed cases cover reset behaviour and a strobe held high.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  localparam int unsigned RGB_CH = 3;
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } parity_e;
endpackage

// File: rtl/vfd_frame_parity.sv
module vfd_frame_parity
  import vfd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_i,
  output parity_e parity_o
);
  logic    frame_q;
  parity_e parity_q;
  logic    boundary;

  assign boundary = frame_i & ~frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= 1'b0;
      parity_q <= PAR_EVEN;
    end else begin
      frame_q <= frame_i;
      if (boundary) parity_q <= (parity_q == PAR_EVEN) ? PAR_ODD : PAR_EVEN;
    end
  end

  assign parity_o = parity_q;

  AST_PARITY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && frame_q) |=> $stable(parity_q)); // R6
  AST_PARITY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(parity_q)); // R6
  AST_PARITY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !frame_q) |=> (parity_q != $past(parity_q))); // R6
endmodule

// File: rtl/vfd_channel_mux.sv
module vfd_channel_mux
  import vfd_pkg::*;
#(
  parameter int unsigned NUM_CH = RGB_CH
) (
  input  logic [NUM_CH-1:0] word_a_i,
  input  logic [NUM_CH-1:0] word_b_i,
  input  parity_e           parity_i,
  input  logic              bypass_i,
  output logic [NUM_CH-1:0] sel_o
);
  // level = a + b; mid level always lit in the even frame
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic lit_even, lit_odd;
    assign lit_even = word_a_i[c] | word_b_i[c];
    assign lit_odd  = word_a_i[c] & word_b_i[c];
    always_comb begin
      if (bypass_i)                  sel_o[c] = word_a_i[c];
      else if (parity_i == PAR_EVEN) sel_o[c] = lit_even;
      else                           sel_o[c] = lit_odd;
    end
  end
endmodule

// File: rtl/vga_frame_dither.sv
module vga_frame_dither
  import vfd_pkg::*;
#(
  parameter int unsigned NUM_CH = RGB_CH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*NUM_CH-1:0] color_i,
  input  logic                active_i,
  input  logic                frame_i,
  input  logic                bypass_i,
  output logic [NUM_CH-1:0]   rgb_o
);
  localparam int unsigned CW = 2 * NUM_CH;

  logic [NUM_CH-1:0] word_a, word_b, sel;
  parity_e           parity;
  logic [NUM_CH-1:0] rgb_q;

  assign word_a = color_i[NUM_CH-1:0];
  assign word_b = color_i[CW-1:NUM_CH];

  vfd_frame_parity u_parity (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .parity_o (parity)
  );

  vfd_channel_mux #(.NUM_CH(NUM_CH)) u_mux (
    .word_a_i (word_a),
    .word_b_i (word_b),
    .parity_i (parity),
    .bypass_i (bypass_i),
    .sel_o    (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rgb_q <= '0;
    else if (!active_i) rgb_q <= '0;
    else                rgb_q <= sel;
  end

  assign rgb_o = rgb_q;

  AST_RESET_DARK: assert property (@(posedge clk_i)
    !rst_ni |-> (rgb_o == '0)); // R1
  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (rgb_o == '0)); // R7
  AST_BYPASS_WORD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && bypass_i) |=> (rgb_o == $past(word_a))); // R8
  AST_EVEN_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !bypass_i && parity == PAR_EVEN) |=> (rgb_o == ($past(word_a) | $past(word_b)))); // R3
  AST_ODD_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !bypass_i && parity == PAR_ODD) |=> (rgb_o == ($past(word_a) & $past(word_b)))); // R4
endmodule

// File: tb/tb_vga_frame_dither.sv
module tb_vga_frame_dither;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] color_i = '0;
  logic       active_i = 1'b0;
  logic       frame_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic [2:0] rgb_o;

  int n_chk = 0, n_fail = 0;
  logic mdl_par = 1'b0, mdl_prev = 1'b0;
  int cnt[3];
  int cnt_even[3];
  logic done = 1'b0;

  always #4 clk_i = ~clk_i;

  vga_frame_dither dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .color_i(color_i), .active_i(active_i),
    .frame_i(frame_i), .bypass_i(bypass_i), .rgb_o(rgb_o)
  );

  function automatic logic [2:0] exp_rgb(input logic [5:0] c, input logic act,
                                         input logic byp, input logic par);
    if (!act) return 3'b000;                  // R7
    if (byp) return c[2:0];                   // R8
    return par ? (c[2:0] & c[5:3])            // R4
               : (c[2:0] | c[5:3]);           // R3
  endfunction

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rgb_o=%b expected %b", req, act, exp);
    end
  endtask

  // drive at negedge, check one edge later (R9)
  task automatic step(input logic [5:0] c, input logic act, input logic frm, input logic byp);
    logic [2:0] e;
    string req;
    color_i = c; active_i = act; frame_i = frm; bypass_i = byp;
    e = exp_rgb(c, act, byp, mdl_par);
    req = !act ? "R7" : byp ? "R8" : mdl_par ? "R4" : "R3";
    if (frm && !mdl_prev) mdl_par = ~mdl_par;
    mdl_prev = frm;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(rgb_o, e, req);
  endtask

  task automatic run_frame(input logic [5:0] c, input logic first);
    for (int p = 0; p < 4; p++) begin
      step(c, 1'b1, 1'b0, 1'b0);
      for (int ch = 0; ch < 3; ch++) begin
        cnt[ch] += int'(rgb_o[ch]);
        if (first) cnt_even[ch] += int'(rgb_o[ch]);
      end
    end
    step(c, 1'b0, 1'b0, 1'b0);
    step(c, 1'b0, 1'b1, 1'b0);
    step(c, 1'b0, 1'b0, 1'b0);
  endtask

  // R5: two-frame on-count per channel equals its level
  task automatic frame_pair(input logic [5:0] c);
    if (mdl_par) run_frame(c, 1'b0);
    for (int ch = 0; ch < 3; ch++) begin cnt[ch] = 0; cnt_even[ch] = 0; end
    run_frame(c, 1'b1);
    run_frame(c, 1'b0);
    for (int ch = 0; ch < 3; ch++) begin
      int lvl = int'(c[ch]) + int'(c[ch+3]);
      n_chk++;
      if (cnt[ch] != 4 * lvl || (lvl == 1 && cnt_even[ch] != 4)) begin
        n_fail++;
        $display("FAIL R5: ch%0d count=%0d even=%0d expected %0d", ch, cnt[ch], cnt_even[ch], 4 * lvl);
      end
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    // R1: dark during reset even with active colour applied
    color_i = 6'h3F; active_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(rgb_o, 3'b000, "R1");
    rst_ni = 1'b1;
    // R1: first frame uses even rule (A=red, B=none -> red lit)
    step(6'b000_100, 1'b1, 1'b0, 1'b0);
    step(6'b001_100, 1'b1, 1'b0, 1'b0);   // R2 bit order
    // R6: strobe held high toggles once only
    for (int i = 0; i < 5; i++) step(6'b000_111, 1'b1, 1'b1, 1'b0);
    step(6'b000_111, 1'b1, 1'b0, 1'b0);
    step(6'b000_111, 1'b1, 1'b1, 1'b0);
    step(6'b000_111, 1'b1, 1'b0, 1'b0);
    // R8: bypass across both parities
    for (int i = 0; i < 4; i++) step(6'b101_010, 1'b1, i[0], 1'b1);
    // R5: all 27 level combinations
    for (int r = 0; r < 3; r++)
      for (int g = 0; g < 3; g++)
        for (int b = 0; b < 3; b++) begin
          logic [2:0] wa, wb;
          wa = {r > 0, g > 0, b > 0};
          wb = {r > 1, g > 1, b > 1};
          frame_pair({wb, wa});
        end
    // mixed random
    for (int i = 0; i < 400; i++)
      step(6'($urandom), ($urandom % 4) != 0, ($urandom % 12) == 0, ($urandom % 8) == 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule